// File: doc/BRIEF.md
# Test-Port Shift Engine

This block is the host side of a four-wire boundary-scan test port. It runs from the system clock and drives the target's test clock, mode-select and serial-data lines. It also reads back the target's serial output. Software-facing logic sends it one command at a time. A command is one of three kinds:

- **State move:** an arbitrary mode-select bit sequence.
- **Instruction-register shift:** a full pass through the instruction register.
- **Data-register shift:** a full pass through the data register.

A register shift starts and ends in the target's run-test/idle state. The engine navigates into the shift state, streams the payload, and returns to idle. Each bit shifted in pushes one bit out of the far end of the register, and those returning bits fill a receive buffer.

Several targets can be daisy-chained. They share the test clock and mode-select line. The engine feeds the first target's serial input and collects from the last target's serial output, so the whole chain is handled as one long register. That register can be as long as `MAX_BITS`. The usual flow is to shift an instruction code first, which selects a data register, and then shift that data register.

The command port is a valid/ready channel:
- A command is taken on a clock edge where both `cmd_valid_i` and `cmd_ready_o` are high.
- `cmd_ready_o` is high only while the engine is idle.
- A producer may hold `cmd_valid_i` and its payload for any time. Nothing is taken until ready returns.

Results are not back-pressured. `rx_data_o` holds the last shift's capture until the next shift is accepted, and `done_o` marks completion.

Top module: `tap_shift_host`

## Requirements
- R1: A command is accepted only on a clock edge with `cmd_valid_i` and `cmd_ready_o` both high. `cmd_ready_o` is high exactly while `busy_o` is low. A command held on the port while the engine is busy has no effect on the wire sequence of the running command.
- R2: `tap_mode_o` and `tap_txd_o` change only in the cycle where `tap_clk_o` falls, or in the cycle where a command is accepted. Both are stable for at least `HALF_DIV` system clocks before each rising edge of `tap_clk_o` and throughout its high phase.
- R3: `tap_clk_o` is low whenever the engine is idle. While a command runs, each high phase and each low phase lasts exactly `HALF_DIV` system clocks, so consecutive rising edges are `2*HALF_DIV` clocks apart.
- R4: Op code 0 (state move) with length N produces N rising edges. At edge k, `tap_mode_o` equals `cmd_bits_i[k]`. `tap_txd_o` stays low, and `rx_data_o` keeps its previous value.
- R5: Op code 1 (instruction shift) with length N produces N+6 rising edges. The mode-select sequence is 1,1,0,0, then the N payload edges, then 1,0.
- R6: Op code 2 (data shift) with length N produces N+5 rising edges. The mode-select sequence is 1,0,0, then the N payload edges, then 1,0.
- R7: On payload edge j of a shift, `tap_txd_o` carries `cmd_bits_i[j]` (least significant bit first). Mode-select is 0 on every payload edge except the last, where it is 1. `tap_txd_o` is low on all non-payload edges.
- R8: On payload edge j, the value of `tap_rxd_i` in the system cycle where `tap_clk_o` rises is stored in `rx_data_o[j]`. `rx_data_o` is cleared when a shift is accepted, so bits at and above the length read 0.
- R9: A shift of the full `MAX_BITS` length behaves like any other length, so a chain of devices can be handled as one register.
- R10: A command with length 0, or with op code 3, produces no edge at all. It leaves `rx_data_o` unchanged and raises `done_o` in the cycle after acceptance.
- R11: `done_o` is a one-cycle pulse. For a command with at least one edge, it is high in the same cycle where `tap_clk_o` falls for the last time, and `busy_o` is low in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command offered |
| cmd_ready_o | output | 1 | Engine can take a command |
| cmd_op_i | input | 2 | 0 move, 1 instruction shift, 2 data shift, 3 no operation |
| cmd_len_i | input | $clog2(MAX_BITS+1) | Number of sequence or payload bits |
| cmd_bits_i | input | MAX_BITS | Mode-select sequence (move) or payload (shift), bit 0 first |
| busy_o | output | 1 | A command is running |
| done_o | output | 1 | One-cycle completion pulse |
| rx_data_o | output | MAX_BITS | Captured serial return bits, bit j from payload edge j |
| tap_clk_o | output | 1 | Generated test clock, idles low |
| tap_mode_o | output | 1 | Mode-select line to all targets |
| tap_txd_o | output | 1 | Serial data into the first target |
| tap_rxd_i | input | 1 | Serial data from the last target |

## Verification
The bound checker watches the test-port timing on every cycle:
- mode-select and serial data held steady around and during each high phase of the generated clock;
- the exact high-phase length;
- the clock resting low when idle;
- acceptance raising busy;
- the zero-length completion;
- the width and position of the done pulse.

Only the bench scenarios can show that the wire sequences are correct: the navigation prefix and suffix for each shift kind, the payload bit order, and the edge counts. The same holds for the mapping of returning serial bits into the receive buffer, the buffer clearing or holding depending on command kind, and a held command being ignored while busy.

// File: rtl/tap_host_pkg.sv
package tap_host_pkg;

  typedef enum logic [1:0] {
    OP_MOVE     = 2'd0,
    OP_SHIFT_IR = 2'd1,
    OP_SHIFT_DR = 2'd2,
    OP_NONE     = 2'd3
  } tap_op_e;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_HIGH = 2'd2
  } phase_e;

  // Edges from run-test/idle into the shift state for each register kind.
  localparam int unsigned IR_LEAD    = 4;
  localparam int unsigned DR_LEAD    = 3;
  // Every lead ends with two mode-select zeros (capture, then shift).
  localparam int unsigned LEAD_ZEROS = 2;
  // Edges from exit back to run-test/idle (update, then idle).
  localparam int unsigned TRAIL      = 2;

endpackage

// File: rtl/tap_phase_timer.sv
module tap_phase_timer #(
  parameter int unsigned HALF_DIV = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tick_o
);

  localparam int unsigned CNT_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF_DIV - 1);

  logic [CNT_W-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (!run_i || tick_o) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/tap_step_planner.sv
module tap_step_planner
  import tap_host_pkg::*;
#(
  parameter int unsigned MAX_BITS = 32
) (
  input  tap_op_e                                  op_i,
  input  logic [$clog2(MAX_BITS+1)-1:0]            len_i,
  input  logic [MAX_BITS-1:0]                      bits_i,
  input  logic [$clog2(MAX_BITS+IR_LEAD+TRAIL+1)-1:0] step_i,
  output logic                                     mode_o,
  output logic                                     txd_o,
  output logic                                     payload_o,
  output logic [((MAX_BITS > 1) ? $clog2(MAX_BITS) : 1)-1:0] pay_idx_o,
  output logic                                     last_o
);

  localparam int unsigned STEP_W = $clog2(MAX_BITS + IR_LEAD + TRAIL + 1);
  localparam int unsigned IDX_W  = (MAX_BITS > 1) ? $clog2(MAX_BITS) : 1;

  logic [STEP_W-1:0] lead;
  logic [STEP_W-1:0] len_ext;
  logic [STEP_W-1:0] rel;
  logic [STEP_W-1:0] total;
  logic              is_shift;

  assign len_ext  = STEP_W'(len_i);
  assign is_shift = (op_i == OP_SHIFT_IR) || (op_i == OP_SHIFT_DR);

  always_comb begin
    unique case (op_i)
      OP_SHIFT_IR: lead = STEP_W'(IR_LEAD);
      OP_SHIFT_DR: lead = STEP_W'(DR_LEAD);
      default:     lead = '0;
    endcase
  end

  assign rel       = step_i - lead;
  assign pay_idx_o = IDX_W'(rel);

  always_comb begin
    mode_o    = 1'b0;
    txd_o     = 1'b0;
    payload_o = 1'b0;
    total     = '0;
    if (op_i == OP_MOVE) begin
      total = len_ext;
      if (step_i < len_ext) begin
        mode_o = bits_i[IDX_W'(step_i)];
      end
    end else if (is_shift) begin
      total = lead + len_ext + STEP_W'(TRAIL);
      if (step_i < lead) begin
        // High while selecting the register column, low for capture and shift.
        mode_o = (step_i < (lead - STEP_W'(LEAD_ZEROS)));
      end else if (rel < len_ext) begin
        payload_o = 1'b1;
        txd_o     = bits_i[IDX_W'(rel)];
        mode_o    = (rel == (len_ext - 1'b1));
      end else begin
        mode_o = (rel == len_ext);
      end
    end
  end

  assign last_o = (total != '0) && (step_i == (total - 1'b1));

endmodule

// File: rtl/tap_capture_buf.sv
module tap_capture_buf #(
  parameter int unsigned MAX_BITS = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                clear_i,
  input  logic                wr_i,
  input  logic [((MAX_BITS > 1) ? $clog2(MAX_BITS) : 1)-1:0] idx_i,
  input  logic                bit_i,
  output logic [MAX_BITS-1:0] data_o
);

  localparam int unsigned IDX_W = (MAX_BITS > 1) ? $clog2(MAX_BITS) : 1;

  for (genvar g = 0; g < MAX_BITS; g++) begin : g_cell
    logic cell_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cell_q <= 1'b0;
      end else if (clear_i) begin
        cell_q <= 1'b0;
      end else if (wr_i && (idx_i == IDX_W'(g))) begin
        cell_q <= bit_i;
      end
    end
    assign data_o[g] = cell_q;
  end

endmodule

// File: rtl/tap_shift_host.sv
module tap_shift_host
  import tap_host_pkg::*;
#(
  parameter int unsigned MAX_BITS = 32,
  parameter int unsigned HALF_DIV = 2
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            cmd_valid_i,
  output logic                            cmd_ready_o,
  input  logic [1:0]                      cmd_op_i,
  input  logic [$clog2(MAX_BITS+1)-1:0]   cmd_len_i,
  input  logic [MAX_BITS-1:0]             cmd_bits_i,
  output logic                            busy_o,
  output logic                            done_o,
  output logic [MAX_BITS-1:0]             rx_data_o,
  output logic                            tap_clk_o,
  output logic                            tap_mode_o,
  output logic                            tap_txd_o,
  input  logic                            tap_rxd_i
);

  localparam int unsigned LEN_W  = $clog2(MAX_BITS + 1);
  localparam int unsigned STEP_W = $clog2(MAX_BITS + IR_LEAD + TRAIL + 1);
  localparam int unsigned IDX_W  = (MAX_BITS > 1) ? $clog2(MAX_BITS) : 1;

  phase_e              state_q;
  tap_op_e             op_q;
  logic [LEN_W-1:0]    len_q;
  logic [MAX_BITS-1:0] pay_q;
  logic [STEP_W-1:0]   step_q;

  logic                clk_q;
  logic                mode_q;
  logic                txd_q;
  logic                slot_pay_q;
  logic [IDX_W-1:0]    slot_idx_q;
  logic                slot_last_q;
  logic                done_q;

  logic                idle;
  logic                tick;
  tap_op_e             cmd_op;
  logic                empty_cmd;
  logic                shift_cmd;

  tap_op_e             sel_op;
  logic [LEN_W-1:0]    sel_len;
  logic [MAX_BITS-1:0] sel_bits;
  logic [STEP_W-1:0]   sel_step;

  logic                nx_mode;
  logic                nx_txd;
  logic                nx_pay;
  logic [IDX_W-1:0]    nx_idx;
  logic                nx_last;

  assign idle      = (state_q == PH_IDLE);
  assign cmd_op    = tap_op_e'(cmd_op_i);
  assign empty_cmd = (cmd_len_i == '0) || (cmd_op == OP_NONE);
  assign shift_cmd = (cmd_op == OP_SHIFT_IR) || (cmd_op == OP_SHIFT_DR);

  // While idle the planner looks at the offered command's first step;
  // while running it looks one step ahead of the current one.
  assign sel_op   = idle ? cmd_op     : op_q;
  assign sel_len  = idle ? cmd_len_i  : len_q;
  assign sel_bits = idle ? cmd_bits_i : pay_q;
  assign sel_step = idle ? '0         : (step_q + 1'b1);

  tap_step_planner #(
    .MAX_BITS (MAX_BITS)
  ) u_planner (
    .op_i      (sel_op),
    .len_i     (sel_len),
    .bits_i    (sel_bits),
    .step_i    (sel_step),
    .mode_o    (nx_mode),
    .txd_o     (nx_txd),
    .payload_o (nx_pay),
    .pay_idx_o (nx_idx),
    .last_o    (nx_last)
  );

  tap_phase_timer #(
    .HALF_DIV (HALF_DIV)
  ) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (!idle),
    .tick_o (tick)
  );

  tap_capture_buf #(
    .MAX_BITS (MAX_BITS)
  ) u_capture (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (cmd_valid_i && idle && !empty_cmd && shift_cmd),
    .wr_i    ((state_q == PH_LOW) && tick && slot_pay_q),
    .idx_i   (slot_idx_q),
    .bit_i   (tap_rxd_i),
    .data_o  (rx_data_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= PH_IDLE;
      op_q        <= OP_MOVE;
      len_q       <= '0;
      pay_q       <= '0;
      step_q      <= '0;
      clk_q       <= 1'b0;
      mode_q      <= 1'b0;
      txd_q       <= 1'b0;
      slot_pay_q  <= 1'b0;
      slot_idx_q  <= '0;
      slot_last_q <= 1'b0;
      done_q      <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        PH_IDLE: begin
          if (cmd_valid_i) begin
            if (empty_cmd) begin
              done_q <= 1'b1;
            end else begin
              op_q        <= cmd_op;
              len_q       <= cmd_len_i;
              pay_q       <= cmd_bits_i;
              step_q      <= '0;
              mode_q      <= nx_mode;
              txd_q       <= nx_txd;
              slot_pay_q  <= nx_pay;
              slot_idx_q  <= nx_idx;
              slot_last_q <= nx_last;
              state_q     <= PH_LOW;
            end
          end
        end
        PH_LOW: begin
          if (tick) begin
            clk_q   <= 1'b1;
            state_q <= PH_HIGH;
          end
        end
        PH_HIGH: begin
          if (tick) begin
            clk_q <= 1'b0;
            if (slot_last_q) begin
              state_q <= PH_IDLE;
              done_q  <= 1'b1;
            end else begin
              step_q      <= step_q + 1'b1;
              mode_q      <= nx_mode;
              txd_q       <= nx_txd;
              slot_pay_q  <= nx_pay;
              slot_idx_q  <= nx_idx;
              slot_last_q <= nx_last;
              state_q     <= PH_LOW;
            end
          end
        end
        default: state_q <= PH_IDLE;
      endcase
    end
  end

  assign cmd_ready_o = idle;
  assign busy_o      = !idle;
  assign done_o      = done_q;
  assign tap_clk_o   = clk_q;
  assign tap_mode_o  = mode_q;
  assign tap_txd_o   = txd_q;

endmodule

// File: rtl/tap_shift_host_chk.sv
module tap_shift_host_chk #(
  parameter int unsigned MAX_BITS = 32,
  parameter int unsigned HALF_DIV = 2
) (
  input logic                          clk_i,
  input logic                          rst_ni,
  input logic                          cmd_valid_i,
  input logic                          cmd_ready_o,
  input logic [1:0]                    cmd_op_i,
  input logic [$clog2(MAX_BITS+1)-1:0] cmd_len_i,
  input logic                          busy_o,
  input logic                          done_o,
  input logic                          tap_clk_o,
  input logic                          tap_mode_o,
  input logic                          tap_txd_o
);

  logic [15:0] hi_run;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        hi_run <= '0;
    else if (tap_clk_o) hi_run <= hi_run + 1'b1;
    else                hi_run <= '0;
  end

  logic take_cmd;
  logic empty_cmd;
  assign take_cmd  = cmd_valid_i && cmd_ready_o;
  assign empty_cmd = (cmd_len_i == '0) || (cmd_op_i == 2'd3);

  AST_ACCEPT_STARTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_cmd && !empty_cmd) |=> (busy_o && !cmd_ready_o)); // R1

  AST_LINES_SETUP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tap_clk_o) |-> ($stable(tap_mode_o) && $stable(tap_txd_o))); // R2

  AST_LINES_HELD_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tap_clk_o && $past(tap_clk_o)) |-> ($stable(tap_mode_o) && $stable(tap_txd_o))); // R2

  AST_CLK_IDLE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !tap_clk_o); // R3

  AST_HIGH_PHASE_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(tap_clk_o) |-> (hi_run == 16'(HALF_DIV))); // R3

  AST_EMPTY_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_cmd && empty_cmd) |=> (done_o && !busy_o && !tap_clk_o)); // R10

  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R11

  AST_DONE_ON_LAST_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(tap_clk_o) && !busy_o) |-> done_o); // R11

endmodule

bind tap_shift_host tap_shift_host_chk #(
  .MAX_BITS (MAX_BITS),
  .HALF_DIV (HALF_DIV)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cmd_valid_i (cmd_valid_i),
  .cmd_ready_o (cmd_ready_o),
  .cmd_op_i    (cmd_op_i),
  .cmd_len_i   (cmd_len_i),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .tap_clk_o   (tap_clk_o),
  .tap_mode_o  (tap_mode_o),
  .tap_txd_o   (tap_txd_o)
);

// File: tb/tap_shift_host_bench.sv
module tap_shift_host_bench;

  localparam int MAXB = 32;
  localparam int HALF = 2;
  localparam int LW   = $clog2(MAXB + 1);

  typedef struct packed {
    logic [1:0]  op;
    logic [7:0]  len;
    logic [31:0] bits;
    logic [63:0] pat;
  } vec_t;

  localparam vec_t VECS [0:5] = '{
    '{2'd1, 8'd4,  32'h0000_000A, 64'hF0F0_1234_A5C3_9E6B},
    '{2'd2, 8'd8,  32'h0000_005C, 64'h0123_4567_89AB_CDEF},
    '{2'd0, 8'd5,  32'h0000_001F, 64'h0000_0000_0000_0000},
    '{2'd2, 8'd32, 32'hC3A5_0F96, 64'hDEAD_BEEF_5A5A_0FF0},
    '{2'd0, 8'd3,  32'h0000_0002, 64'hFFFF_FFFF_FFFF_FFFF},
    '{2'd1, 8'd1,  32'h0000_0001, 64'hFFFF_FFFF_FFFF_FFEF}
  };

  logic            clk = 1'b0;
  logic            rst_ni = 1'b0;
  logic            cmd_valid = 1'b0;
  logic            cmd_ready;
  logic [1:0]      cmd_op = 2'd0;
  logic [LW-1:0]   cmd_len = '0;
  logic [MAXB-1:0] cmd_bits = '0;
  logic            busy, done;
  logic [MAXB-1:0] rx_data;
  logic            tap_clk, tap_mode, tap_txd;
  logic            tap_rxd = 1'b0;

  always #2 clk = ~clk;

  tap_shift_host #(.MAX_BITS(MAXB), .HALF_DIV(HALF)) u_tap_shift_host (
    .clk_i (clk), .rst_ni (rst_ni),
    .cmd_valid_i (cmd_valid), .cmd_ready_o (cmd_ready),
    .cmd_op_i (cmd_op), .cmd_len_i (cmd_len), .cmd_bits_i (cmd_bits),
    .busy_o (busy), .done_o (done), .rx_data_o (rx_data),
    .tap_clk_o (tap_clk), .tap_mode_o (tap_mode), .tap_txd_o (tap_txd),
    .tap_rxd_i (tap_rxd)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit finished = 0;

  // Target-side observer: logs lines at each rising test-clock edge.
  int          rise_cnt = 0;
  logic        log_mode [64];
  logic        log_txd  [64];
  int          rise_t   [64];
  int          setup_bad = 0;
  logic        mode_neg, txd_neg;
  logic [63:0] cur_pat = '0;

  always @(negedge clk) begin
    cyc++;
    mode_neg = tap_mode;
    txd_neg  = tap_txd;
  end

  always @(posedge tap_clk) begin
    if (rise_cnt < 64) begin
      log_mode[rise_cnt] = tap_mode;
      log_txd[rise_cnt]  = tap_txd;
      rise_t[rise_cnt]   = cyc;
    end
    if (tap_mode !== mode_neg || tap_txd !== txd_neg) setup_bad++;
    rise_cnt++;
  end

  // The target presents its next return bit after each falling edge.
  always @(negedge tap_clk) begin
    if (rise_cnt < 64) tap_rxd = cur_pat[rise_cnt];
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int lead_of(input int op);
    return (op == 1) ? 4 : ((op == 2) ? 3 : 0);
  endfunction

  function automatic int exp_total(input int op, input int len);
    if (len == 0 || op == 3) return 0;
    if (op == 0) return len;
    return lead_of(op) + len + 2;
  endfunction

  function automatic logic exp_mode(input int op, input int len, input logic [31:0] bits, input int k);
    int pre = lead_of(op);
    if (op == 0) return bits[k];
    if (k < pre) return (op == 1) ? (k < 2) : (k == 0);
    if (k - pre < len) return (k - pre == len - 1);
    return (k - pre == len);
  endfunction

  function automatic logic exp_txd(input int op, input int len, input logic [31:0] bits, input int k);
    int pre = lead_of(op);
    if (op == 0) return 1'b0;
    if (k >= pre && k < pre + len) return bits[k - pre];
    return 1'b0;
  endfunction

  logic [MAXB-1:0] exp_rx = '0;
  int   wait_n;
  logic busy_at_done, done_next;

  task automatic run_cmd(input logic [1:0] op, input int len, input logic [31:0] bits,
                         input logic [63:0] pat);
    cur_pat   = pat;
    rise_cnt  = 0;
    setup_bad = 0;
    tap_rxd   = pat[0];
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_op    = op;
    cmd_len   = LW'(len);
    cmd_bits  = bits;
    @(negedge clk);
    cmd_valid = 1'b0;
    wait_n = 0;
    while (!done && wait_n < 5000) begin
      @(negedge clk);
      wait_n++;
    end
    if (wait_n >= 5000) check(0, "R11", "done timeout", 0, 1);
    busy_at_done = busy;
    @(negedge clk);
    done_next = done;
  endtask

  task automatic run_vec(input vec_t v);
    int op  = int'(v.op);
    int len = int'(v.len);
    int n   = exp_total(op, len);
    int mode_bad = 0, txd_bad = 0, per_bad = 0;
    string tag;
    tag = (op == 0) ? "R4" : ((op == 1) ? "R5" : "R6");
    run_cmd(v.op, len, v.bits, v.pat);
    check(rise_cnt == n, tag, "edge count", rise_cnt, n);
    for (int k = 0; k < n && k < 64; k++) begin
      if (log_mode[k] !== exp_mode(op, len, v.bits, k)) mode_bad++;
      if (log_txd[k]  !== exp_txd(op, len, v.bits, k))  txd_bad++;
      if (k > 0 && rise_t[k] - rise_t[k-1] != 2 * HALF) per_bad++;
    end
    check(mode_bad == 0, tag, "mode-select mismatches", mode_bad, 0);
    check(txd_bad == 0, "R7", "serial-out mismatches", txd_bad, 0);
    check(per_bad == 0, "R3", "edge spacing errors", per_bad, 0);
    check(setup_bad == 0, "R2", "lines moved before rising edge", setup_bad, 0);
    // R4: a move must leave exp_rx untouched; a shift rebuilds it.
    if (op == 1 || op == 2) begin
      exp_rx = '0;
      for (int j = 0; j < len; j++) exp_rx[j] = v.pat[lead_of(op) + j];
    end
    check(rx_data === exp_rx, (op == 0) ? "R4" : "R8", "rx_data", rx_data, exp_rx);
    check(!busy_at_done && !done_next, "R11", "done pulse shape", {busy_at_done, done_next}, 0);
    if (len == MAXB)
      check(rise_cnt == MAXB + 5 && rx_data === exp_rx, "R9", "full-chain shift", rise_cnt, MAXB + 5);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=%0d expected=0", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int ready_bad;
    int txd_bad;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // Reset state
    check(!tap_clk && !busy && cmd_ready && !done, "R3", "reset outputs",
          {tap_clk, busy, cmd_ready, done}, 4'b0010);
    check(rx_data == '0, "R8", "reset rx_data", rx_data, 0);

    foreach (VECS[i]) run_vec(VECS[i]);

    // R10: zero length and op code 3 produce no edge and finish at once
    run_cmd(2'd2, 0, 32'hFFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF);
    check(rise_cnt == 0 && wait_n == 0, "R10", "zero-length data shift", rise_cnt, 0);
    check(rx_data === exp_rx, "R10", "rx kept on zero length", rx_data, exp_rx);
    run_cmd(2'd3, 7, 32'h7F, 64'h0);
    check(rise_cnt == 0 && wait_n == 0, "R10", "op code 3", rise_cnt, 0);
    check(!busy_at_done && !done_next, "R11", "empty done pulse", {busy_at_done, done_next}, 0);

    // R1: a second command held while busy is not taken
    cur_pat   = '0;
    rise_cnt  = 0;
    tap_rxd   = 1'b0;
    ready_bad = 0;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 2'd2; cmd_len = LW'(8); cmd_bits = 32'h96;
    @(negedge clk);
    cmd_op = 2'd1; cmd_len = LW'(3); cmd_bits = 32'h7;
    repeat (20) begin
      if (cmd_ready) ready_bad++;
      @(negedge clk);
    end
    cmd_valid = 1'b0;
    wait_n = 0;
    while (!done && wait_n < 5000) begin
      @(negedge clk);
      wait_n++;
    end
    check(ready_bad == 0, "R1", "ready while busy", ready_bad, 0);
    check(rise_cnt == 13, "R1", "edge count of first command", rise_cnt, 13);
    txd_bad = 0;
    for (int k = 0; k < 13; k++)
      if (log_txd[k] !== exp_txd(2, 8, 32'h96, k)) txd_bad++;
    check(txd_bad == 0, "R1", "payload of first command", txd_bad, 0);
    repeat (4) @(negedge clk);
    check(!busy && cmd_ready && rise_cnt == 13, "R1", "no second start", rise_cnt, 13);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule